// File: doc/BRIEF.md
# Radix-16 Iterative Multiply-Accumulate Unit

This block forms a product one hexadecimal digit of the multiplier at a time. A 48-bit shift-accumulator does two jobs. Its lower half first holds the multiplier. Its upper half collects the running sum. In each run cycle the lowest four accumulator bits are taken as a digit. The digit is multiplied by the stored 24-bit multiplicand to give a 28-bit partial product. That partial product is added to the upper 24 accumulator bits, and the carry is kept. The 28-bit sum, placed above the remaining bits, forms a register value that is one nibble to the right. The digit just used falls off the bottom, and the next digit takes its place. After four run cycles a 16-bit multiplier has been used up. The product then sits in the upper 40 accumulator bits.

The multiplicand is built from two operand buses. The low bus `opa_i` gives bits 15..0. In unsigned mode the second bus `opb_i` gives bits 23..16. In signed mode `opa_i` is sign-extended to 24 bits, and the final digit is read as a signed value from -8 to 7. This makes the result the exact two's-complement product.

Operands enter through a valid/ready handshake. A transfer happens only on a rising edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is low while a multiply runs and while a result waits to be taken. A producer must therefore hold its operands until the transfer. Any `in_valid_i` it raises while the unit is not ready has no effect. The result leaves through a second valid/ready pair. It stays on `result_o` until the edge where `out_ready_i` is seen high. `busy_o` and `done_o` are plain status pins.

Top module: `r16_mac`

## Requirements
- R1: `in_ready_o` is high exactly when no multiply is running and no result is pending. A rising edge with `in_valid_i` and `in_ready_o` both high captures `opa_i`, `opb_i`, `mplr_i` and `signed_i`. `busy_o` is high in the cycle after that edge.
- R2: `out_valid_o` rises on the fourth rising edge after the accepting edge. `busy_o` is high for the four cycles between those edges and low once the result is valid.
- R3: `done_o` is a one-cycle pulse. It is high in the first cycle `out_valid_o` is high and low in every later cycle of the same result.
- R4: With `signed_i` = 0, `result_o` equals the unsigned 40-bit product of the 24-bit value {`opb_i`, `opa_i`} and the unsigned 16-bit `mplr_i`. This includes the all-ones operands.
- R5: With `signed_i` = 1, `result_o` equals the two's-complement product of `opa_i` and `mplr_i`, sign-extended to 40 bits. `opb_i` has no effect. -32768 × -32768 gives 2^30.
- R6: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and `result_o` stay unchanged. After an edge with both high, `out_valid_o` is low and `in_ready_o` is high.
- R7: `in_valid_i` raised while a multiply runs with other operands does not change the result being computed. It produces no further result after that one is taken.
- R8: During and right after reset, `in_ready_o` is 1 and `out_valid_o`, `busy_o` and `done_o` are 0.
- R9: A zero multiplier or a zero multiplicand yields a result of 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands on the input buses are offered |
| in_ready_o | output | 1 | Unit can take a new operand set |
| opa_i | input | 16 | Multiplicand bits 15..0 (first operand bus) |
| opb_i | input | 8 | Multiplicand bits 23..16 in unsigned mode (second operand bus) |
| mplr_i | input | 16 | Multiplier, loaded into the low accumulator bits |
| signed_i | input | 1 | 1: two's-complement 16x16, 0: unsigned 24x16 |
| out_valid_o | output | 1 | Product on `result_o` is valid |
| out_ready_i | input | 1 | Consumer takes the product |
| result_o | output | 40 | Product, upper 40 accumulator bits |
| busy_o | output | 1 | A multiply is in its run cycles |
| done_o | output | 1 | One-cycle pulse when a product first becomes valid |

## Verification
A wrong internal state shows up at the ports within one operation. A digit taken from the wrong bits, a lost carry out of the 24-bit add, or a missing sign on the final digit gives a wrong `result_o` once `out_valid_o` rises. Products with dense bit patterns and the most negative operands make each of these faults visible. A sequencer that counts one run cycle too few or too many shifts the rising edge of `out_valid_o` away from the fourth edge. The bench checks that cycle exactly. A capture path that reacts to a request while busy changes the product, or leaves a second result behind, within the few cycles after the first result is taken.

// File: rtl/r16_mac_pkg.sv
`timescale 1ns/1ps
package r16_mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } mac_state_e;
endpackage

// File: rtl/r16_mac_pp.sv
`timescale 1ns/1ps
// Partial product of one multiplier digit and the multiplicand.
module r16_mac_pp #(
  parameter int MCAND_W = 24,
  parameter int DIGIT_W = 4
) (
  input  logic [MCAND_W-1:0]         mcand_i,
  input  logic [DIGIT_W-1:0]         digit_i,
  input  logic                       sgn_i,
  input  logic                       top_digit_i,
  output logic [MCAND_W+DIGIT_W-1:0] pp_o
);
  localparam int PP_W = MCAND_W + DIGIT_W;

  logic [PP_W-1:0] mcand_x;
  logic [PP_W-1:0] term [DIGIT_W];

  assign mcand_x = sgn_i ? {{DIGIT_W{mcand_i[MCAND_W-1]}}, mcand_i}
                         : {{DIGIT_W{1'b0}}, mcand_i};

  generate
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_term
      assign term[i] = digit_i[i] ? (mcand_x << i) : '0;
    end
  endgenerate

  // The top bit of the final digit carries negative weight in signed mode.
  always_comb begin
    pp_o = '0;
    for (int i = 0; i < DIGIT_W; i++) begin
      if ((i == DIGIT_W - 1) && sgn_i && top_digit_i) pp_o = pp_o - term[i];
      else                                            pp_o = pp_o + term[i];
    end
  end
endmodule

// File: rtl/r16_mac_acc.sv
`timescale 1ns/1ps
// Shared shift-accumulator: multiplier source in the low half, sum above.
module r16_mac_acc #(
  parameter int MCAND_W = 24,
  parameter int MPLR_W  = 16,
  parameter int DIGIT_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic                       step_i,
  input  logic                       sgn_i,
  input  logic [MCAND_W-1:0]         mcand_i,
  input  logic [MPLR_W-1:0]          mplr_i,
  input  logic [MCAND_W+DIGIT_W-1:0] pp_i,
  output logic [DIGIT_W-1:0]         digit_o,
  output logic [MCAND_W-1:0]         mcand_q_o,
  output logic                       sgn_q_o,
  output logic [MCAND_W+MPLR_W-1:0]  res_o
);
  localparam int ACC_W = 2 * MCAND_W;
  localparam int PP_W  = MCAND_W + DIGIT_W;
  localparam int ALIGN = MCAND_W - MPLR_W;

  logic [ACC_W-1:0]   acc_q;
  logic [MCAND_W-1:0] mcand_q;
  logic               sgn_q;
  logic [PP_W-1:0]    hi_x;
  logic [PP_W-1:0]    top_sum;

  assign hi_x = sgn_q ? {{DIGIT_W{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:MCAND_W]}
                      : {{DIGIT_W{1'b0}}, acc_q[ACC_W-1:MCAND_W]};
  assign top_sum = hi_x + pp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mcand_q <= '0;
      sgn_q   <= 1'b0;
    end else if (load_i) begin
      acc_q   <= {{(ACC_W-MPLR_W){1'b0}}, mplr_i};
      mcand_q <= mcand_i;
      sgn_q   <= sgn_i;
    end else if (step_i) begin
      acc_q   <= {top_sum, acc_q[MCAND_W-1:DIGIT_W]};
    end
  end

  assign digit_o   = acc_q[DIGIT_W-1:0];
  assign mcand_q_o = mcand_q;
  assign sgn_q_o   = sgn_q;
  assign res_o     = acc_q[ACC_W-1:ALIGN];
endmodule

// File: rtl/r16_mac_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accept, run ITERS digit cycles, hold result until taken.
module r16_mac_ctrl
  import r16_mac_pkg::*;
#(
  parameter int ITERS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic out_ready_i,
  output logic in_ready_o,
  output logic load_o,
  output logic step_o,
  output logic top_o,
  output logic busy_o,
  output logic out_valid_o,
  output logic done_o
);
  localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;

  mac_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign in_ready_o  = (state_q == ST_IDLE);
  assign load_o      = in_ready_o && in_valid_i;
  assign step_o      = (state_q == ST_RUN);
  assign top_o       = step_o && (cnt_q == CNT_W'(ITERS - 1));
  assign busy_o      = step_o;
  assign out_valid_o = (state_q == ST_HOLD);
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (top_o) begin
            state_q <= ST_HOLD;
            done_q  <= 1'b1;
          end
        end
        ST_HOLD: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/r16_mac.sv
`timescale 1ns/1ps
module r16_mac #(
  parameter int MCAND_W = 24,
  parameter int OPA_W   = 16,
  parameter int MPLR_W  = 16,
  parameter int DIGIT_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [OPA_W-1:0]          opa_i,
  input  logic [MCAND_W-OPA_W-1:0]  opb_i,
  input  logic [MPLR_W-1:0]         mplr_i,
  input  logic                      signed_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [MCAND_W+MPLR_W-1:0] result_o,
  output logic                      busy_o,
  output logic                      done_o
);
  localparam int OPB_W = MCAND_W - OPA_W;
  localparam int PP_W  = MCAND_W + DIGIT_W;
  localparam int ITERS = MPLR_W / DIGIT_W;
  localparam int RES_W = MCAND_W + MPLR_W;

  logic [MCAND_W-1:0] mcand_in;
  logic [MCAND_W-1:0] mcand_q;
  logic [DIGIT_W-1:0] digit;
  logic [PP_W-1:0]    pp;
  logic               sgn_q;
  logic               load, step, top;

  assign mcand_in = signed_i ? {{OPB_W{opa_i[OPA_W-1]}}, opa_i} : {opb_i, opa_i};

  r16_mac_ctrl #(.ITERS(ITERS)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .out_ready_i(out_ready_i),
    .in_ready_o (in_ready_o),
    .load_o     (load),
    .step_o     (step),
    .top_o      (top),
    .busy_o     (busy_o),
    .out_valid_o(out_valid_o),
    .done_o     (done_o)
  );

  r16_mac_pp #(.MCAND_W(MCAND_W), .DIGIT_W(DIGIT_W)) pp_i (
    .mcand_i    (mcand_q),
    .digit_i    (digit),
    .sgn_i      (sgn_q),
    .top_digit_i(top),
    .pp_o       (pp)
  );

  r16_mac_acc #(.MCAND_W(MCAND_W), .MPLR_W(MPLR_W), .DIGIT_W(DIGIT_W)) acc_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .sgn_i    (signed_i),
    .mcand_i  (mcand_in),
    .mplr_i   (mplr_i),
    .pp_i     (pp),
    .digit_o  (digit),
    .mcand_q_o(mcand_q),
    .sgn_q_o  (sgn_q),
    .res_o    (result_o)
  );
endmodule

// File: rtl/r16_mac_chk.sv
`timescale 1ns/1ps
module r16_mac_chk #(
  parameter int ITERS = 4,
  parameter int RES_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o
);
  logic [7:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       run_cnt <= '0;
    else if (in_valid_i && in_ready_o) run_cnt <= '0;
    else if (busy_o)                   run_cnt <= run_cnt + 1'b1;
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (!busy_o && !out_valid_o)); // R1
  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> busy_o); // R1
  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (run_cnt == 8'(ITERS))); // R2
  AST_DONE_WITH_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(out_valid_o)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o))); // R6
  AST_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> (!out_valid_o && in_ready_o)); // R6
  AST_BUSY_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && in_valid_i) |=> !in_ready_o || !busy_o); // R7
endmodule

bind r16_mac r16_mac_chk #(.ITERS(ITERS), .RES_W(RES_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/r16_mac_tb_top.sv
`timescale 1ns/1ps
module r16_mac_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] opa = '0;
  logic [7:0]  opb = '0;
  logic [15:0] mplr = '0;
  logic        sgn = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [39:0] result;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  r16_mac dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .opa_i(opa), .opb_i(opb), .mplr_i(mplr), .signed_i(sgn),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .result_o(result),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] model(input logic [15:0] a, input logic [7:0] b,
                                        input logic [15:0] m, input logic s);
    longint p;
    if (s) p = longint'($signed(a)) * longint'($signed(m));
    else   p = longint'({b, a}) * longint'(m);
    return p[39:0];
  endfunction

  // One operation: offer, count run cycles, check result, hold, take.
  task automatic run_op(input logic [15:0] a, input logic [7:0] b,
                        input logic [15:0] m, input logic s,
                        input int hold, input bit poke, input string req);
    logic [39:0] exp;
    exp = model(a, b, m, s);
    @(negedge clk);
    opa = a; opb = b; mplr = m; sgn = s; in_valid = 1'b1;
    chk("R1", "ready before offer", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    opa = ~a; opb = ~b; mplr = ~m; sgn = ~s;
    chk("R1", "busy after accept", {busy, in_ready}, 2'b10);
    for (int k = 0; k < 3; k++) begin
      if (poke && k == 0) in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2", "no result before fourth edge", out_valid, 0);
    end
    @(negedge clk);
    chk("R2", "result valid at fourth edge", {out_valid, busy}, 2'b10);
    chk("R3", "done with first valid", done, 1);
    chk(req, "product", result, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R3", "done only once", done, 0);
      chk("R6", "held under back-pressure", {out_valid, result}, {1'b1, exp});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R6", "cleared after take", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R8", "state in reset", {in_ready, out_valid, busy, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "state after reset", {in_ready, out_valid, busy, done}, 4'b1000);
  endtask

  task automatic test_unsigned();
    run_op(16'h1234, 8'h00, 16'h0005, 1'b0, 0, 1'b0, "R4");
    run_op(16'hBEEF, 8'hA5, 16'hC3D2, 1'b0, 0, 1'b0, "R4");
    run_op(16'hFFFF, 8'hFF, 16'hFFFF, 1'b0, 0, 1'b0, "R4");
    run_op(16'h0001, 8'h80, 16'h8000, 1'b0, 0, 1'b0, "R4");
  endtask

  task automatic test_signed();
    run_op(16'h8000, 8'h5A, 16'h8000, 1'b1, 0, 1'b0, "R5");
    run_op(16'hFFFF, 8'h00, 16'h7FFF, 1'b1, 0, 1'b0, "R5");
    run_op(16'h7FFF, 8'hFF, 16'h8000, 1'b1, 0, 1'b0, "R5");
    run_op(16'hF00D, 8'h3C, 16'h0F0F, 1'b1, 0, 1'b0, "R5");
    run_op(16'h0123, 8'hFF, 16'hFFF7, 1'b1, 0, 1'b0, "R5");
  endtask

  task automatic test_zero();
    run_op(16'h0000, 8'h00, 16'hABCD, 1'b0, 0, 1'b0, "R9");
    run_op(16'h8001, 8'hFF, 16'h0000, 1'b0, 0, 1'b0, "R9");
    run_op(16'h0000, 8'h77, 16'h8000, 1'b1, 0, 1'b0, "R9");
    run_op(16'h9999, 8'h00, 16'h0000, 1'b1, 0, 1'b0, "R9");
  endtask

  task automatic test_backpressure();
    run_op(16'h5A5A, 8'h3C, 16'h1357, 1'b0, 4, 1'b0, "R6");
    run_op(16'hC001, 8'h00, 16'h9ABC, 1'b1, 2, 1'b0, "R6");
  endtask

  task automatic test_busy_ignored();
    run_op(16'h4321, 8'h12, 16'h0F0F, 1'b0, 1, 1'b1, "R7");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R7", "no extra result", {out_valid, busy, in_ready}, 3'b001);
    end
  endtask

  initial begin
    test_reset();
    test_unsigned();
    test_signed();
    test_zero();
    test_backpressure();
    test_busy_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule